// File: doc/BRIEF.md
# Dithered MASH Fractional Divide Controller

This block sets the modulus of a multi-modulus feedback divider, which divides the oscillator down to the reference. Each reference-cycle strobe advances it one step, and it then issues one signed divide value. Over a whole pattern period, the mean of these values is exactly N + F/M. The modulus M is programmable to any value from 1 upwards, so it need not be a power of two. F is the numerator.

Two noise-shaping modes are available.
- **First-order mode** uses a single modulus-M accumulator. Its carry selects between N and N+1.
- **Third-order mode** cascades three such accumulators. It merges their carries through delayed differences, giving an offset from -3 to +4.

A 15-bit pseudo-random sequence can be fed into the first accumulator as an extra 0/1 term. This breaks up the short repeating patterns that simple fractions produce.

The divider counter, the phase detector and the loop itself lie outside the block. A system integrator wires the divide value and its valid pulse into the divider's load logic.

Top module: `frac_div_ctrl`

## Requirements
- R1: With dither off, the sum of the divide values over a whole pattern period equals period·N + period·F/M exactly. This holds in both orders. In third order, the period is M³ and the window starts after the first M³ values following reset.
- R2: In first-order mode, every divide value is N or N+1.
- R3: In first-order mode with F=1 and M=2, the values alternate strictly, and the first value after reset is N.
- R4: In third-order mode (order3=1), every divide value lies in N-3..N+4.
- R5: Any modulus works, including values that are not powers of two (for example 5 and 7). R1 holds for them.
- R6: A numerator F ≥ M is handled as F = M-1. A modulus of 0 is handled as 1.
- R7: With dither_en=1, the least significant bit of a 15-bit LFSR (taps x^15+x^14+1, seed 1, advancing on every strobe) is added into the first accumulator. With F=0 and dither on, some values rise above N. With F=0 and dither off, every value is N.
- R8: div_vld pulses exactly one clock after each ref_stb. With no strobe, div_vld stays 0 and div_val holds its value.
- R9: Reset clears every accumulator and delay register, and sets div_val=0 and div_vld=0. In third order with F=1 and M=4, the first value after reset is N.
- R10: div_val is signed and two bits wider than N. With N=0 in third order, negative offsets are carried correctly, and R1 still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_stb | input | 1 | One-cycle strobe per reference period; advances the modulator |
| order3 | input | 1 | 1 selects third-order MASH, 0 selects first order |
| dither_en | input | 1 | Enables the pseudo-random term into the first accumulator |
| int_n | input | INT_W | Integer part N |
| frac_num | input | FRAC_W | Numerator F |
| frac_mod | input | FRAC_W | Modulus M |
| div_val | output | INT_W+2 | Signed instantaneous divide value |
| div_vld | output | 1 | Pulse marking a new div_val |

## Verification
A wrong accumulator residue or a dropped carry does not always show up in one sample. It does show up as a mean error over the first full period, which is at most M³ strobes in third order. The windowed sums are therefore exact integer comparisons.

A bad delay register in the combiner appears sooner. It pushes an offset outside -3..+4 within a few strobes, or breaks the strict alternation at F/M=1/2 on the second value. Strobe and valid misalignment is visible on the very next clock.

// File: rtl/frac_pkg.sv
`timescale 1ns/1ps
package frac_pkg;
  localparam int NSTAGE   = 3;
  localparam int OFF_W    = 4;
  localparam int LFSR_W   = 15;

  typedef enum logic {
    SHAPE_FIRST = 1'b0,
    SHAPE_THIRD = 1'b1
  } shape_e;
endpackage

// File: rtl/mod_accum.sv
`timescale 1ns/1ps
module mod_accum #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] modulus,
  input  logic [W-1:0] addend,
  input  logic         extra,
  output logic [W-1:0] residue,
  output logic         carry
);
  localparam int SW = W + 1;

  logic [W-1:0]  state_q;
  logic [SW-1:0] sum;
  logic [SW-1:0] wrapped;

  always_comb begin
    sum     = {1'b0, state_q} + {1'b0, addend} + {{W{1'b0}}, extra};
    carry   = (sum >= {1'b0, modulus});
    wrapped = sum - {1'b0, modulus};
    residue = carry ? wrapped[W-1:0] : sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (en) begin
      state_q <= residue;
    end
  end
endmodule

// File: rtl/dither_lfsr.sv
`timescale 1ns/1ps
module dither_lfsr #(
  parameter int                W    = 15,
  parameter logic [W-1:0]      SEED = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic bit_o
);
  logic [W-1:0] q_q;
  logic [W-1:0] q_d;
  logic         fb;

  always_comb begin
    fb    = q_q[W-1] ^ q_q[W-2];
    q_d   = {q_q[W-2:0], fb};
    bit_o = q_q[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= SEED;
    end else if (en) begin
      q_q <= q_d;
    end
  end
endmodule

// File: rtl/mash_comb.sv
`timescale 1ns/1ps
module mash_comb
  import frac_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  shape_e                  shape,
  input  logic [NSTAGE-1:0]       carries,
  output logic signed [OFF_W-1:0] offset
);
  logic c2_d_q, c3_d_q, c3_dd_q;
  logic signed [OFF_W-1:0] t1, t2, t3;

  always_comb begin
    t1 = $signed({3'b000, carries[0]});
    t2 = $signed({3'b000, carries[1]}) - $signed({3'b000, c2_d_q});
    t3 = $signed({3'b000, carries[2]}) - $signed({2'b00, c3_d_q, 1'b0})
       + $signed({3'b000, c3_dd_q});
    if (shape == SHAPE_THIRD) begin
      offset = t1 + t2 + t3;
    end else begin
      offset = t1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c2_d_q  <= 1'b0;
      c3_d_q  <= 1'b0;
      c3_dd_q <= 1'b0;
    end else if (en) begin
      c2_d_q  <= carries[1];
      c3_d_q  <= carries[2];
      c3_dd_q <= c3_d_q;
    end
  end
endmodule

// File: rtl/frac_div_ctrl.sv
`timescale 1ns/1ps
module frac_div_ctrl
  import frac_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ref_stb,
  input  logic                     order3,
  input  logic                     dither_en,
  input  logic [INT_W-1:0]         int_n,
  input  logic [FRAC_W-1:0]        frac_num,
  input  logic [FRAC_W-1:0]        frac_mod,
  output logic signed [INT_W+1:0]  div_val,
  output logic                     div_vld
);
  localparam int OW = INT_W + 2;

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [FRAC_W-1:0] eff_mod;
  logic [FRAC_W-1:0] eff_num;
  shape_e            shape;

  always_comb begin
    eff_mod = (frac_mod == '0) ? {{(FRAC_W-1){1'b0}}, 1'b1} : frac_mod;
    eff_num = (frac_num >= eff_mod) ? (eff_mod - 1'b1) : frac_num;
    shape   = order3 ? SHAPE_THIRD : SHAPE_FIRST;
  end

  logic dith_bit;

  dither_lfsr #(.W(LFSR_W), .SEED(LFSR_W'(1))) i_lfsr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (ref_stb),
    .bit_o (dith_bit)
  );

  logic [FRAC_W-1:0] residue [NSTAGE];
  logic [NSTAGE-1:0] carries;

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    logic [FRAC_W-1:0] addend;
    logic              extra;
    if (g == 0) begin : g_head
      assign addend = eff_num;
      assign extra  = dither_en & dith_bit;
    end else begin : g_tail
      assign addend = residue[g-1];
      assign extra  = 1'b0;
    end
    mod_accum #(.W(FRAC_W)) i_acc (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .en      (ref_stb),
      .modulus (eff_mod),
      .addend  (addend),
      .extra   (extra),
      .residue (residue[g]),
      .carry   (carries[g])
    );
  end

  logic signed [OFF_W-1:0] offset;

  mash_comb i_comb (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en      (ref_stb),
    .shape   (shape),
    .carries (carries),
    .offset  (offset)
  );

  logic signed [OW-1:0] val_d;
  logic                 vld_d;

  always_comb begin
    val_d = $signed({2'b00, int_n}) + {{(OW-OFF_W){offset[OFF_W-1]}}, offset};
    vld_d = ref_stb;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      div_val <= '0;
      div_vld <= 1'b0;
    end else begin
      div_vld <= vld_d;
      if (ref_stb) begin
        div_val <= val_d;
      end
    end
  end
endmodule

// File: rtl/frac_div_ctrl_chk.sv
`timescale 1ns/1ps
module frac_div_ctrl_chk #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ref_stb,
  input logic                    order3,
  input logic [INT_W-1:0]        int_n,
  input logic [FRAC_W-1:0]       frac_num,
  input logic [FRAC_W-1:0]       frac_mod,
  input logic signed [INT_W+1:0] div_val,
  input logic                    div_vld
);
  // R2
  first_order_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_vld && !$past(order3)) |->
      (int'(div_val) >= int'($past(int_n)) && int'(div_val) <= int'($past(int_n)) + 1));

  // R4
  third_order_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_vld && $past(order3)) |->
      (int'(div_val) >= int'($past(int_n)) - 3 && int'(div_val) <= int'($past(int_n)) + 4));

  // R3
  half_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_vld && $past(div_vld) && !$past(order3) && $past(frac_num) == 1 && $past(frac_mod) == 2)
      |-> (div_val != $past(div_val)));

  // R8
  strobe_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_stb |=> div_vld);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_stb |=> (!div_vld && $stable(div_val)));
endmodule

bind frac_div_ctrl frac_div_ctrl_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .ref_stb  (ref_stb),
  .order3   (order3),
  .int_n    (int_n),
  .frac_num (frac_num),
  .frac_mod (frac_mod),
  .div_val  (div_val),
  .div_vld  (div_vld)
);

// File: tb/test_frac_div_ctrl.sv
`timescale 1ns/1ps
module test_frac_div_ctrl;
  localparam int INT_W   = 8;
  localparam int FRAC_W  = 16;
  localparam int CLK_PER = 10;
  localparam int NVEC    = 8;

  // columns: order3, N, F, M, skip, len, tag id
  localparam int VEC [NVEC][7] = '{
    '{0, 100, 1, 4,   0,   4, 1},
    '{1, 100, 1, 4,  64,  64, 1},
    '{0,  37, 3, 5,   0,  10, 5},
    '{1,  37, 3, 5, 125, 125, 5},
    '{1,   0, 1, 4,  64,  64, 10},
    '{0,  20, 7, 5,   0,   5, 6},
    '{1,  20, 9, 7, 343, 343, 6},
    '{0, 200, 5, 7,   0,  14, 5}
  };

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic                    ref_stb;
  logic                    order3;
  logic                    dither_en;
  logic [INT_W-1:0]        int_n;
  logic [FRAC_W-1:0]       frac_num;
  logic [FRAC_W-1:0]       frac_mod;
  logic signed [INT_W+1:0] div_val;
  logic                    div_vld;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PER/2) clk = ~clk;

  frac_div_ctrl #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_frac_div_ctrl (
    .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .order3(order3),
    .dither_en(dither_en), .int_n(int_n), .frac_num(frac_num),
    .frac_mod(frac_mod), .div_val(div_val), .div_vld(div_vld)
  );

  function automatic string tag_of(input int id);
    case (id)
      1:  return "R1";
      5:  return "R5";
      6:  return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic o3, input logic de, input int n, input int f, input int m);
    @(negedge clk);
    ref_stb = 1'b0; order3 = o3; dither_en = de;
    int_n = INT_W'(n); frac_num = FRAC_W'(f); frac_mod = FRAC_W'(m);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Collect cnt values; returns sum, min, max, first two values
  task automatic collect(input int cnt, input int skip, output longint sum,
                         output int lo, output int hi, output int v0, output int v1,
                         output int alt_bad);
    int got = 0;
    int prev = 0;
    sum = 0; lo = 1 << 30; hi = -(1 << 30); v0 = 0; v1 = 0; alt_bad = 0;
    ref_stb = 1'b1;
    while (got < skip + cnt) begin
      @(negedge clk);
      if (div_vld) begin
        if (got == 0) v0 = int'(div_val);
        if (got == 1) v1 = int'(div_val);
        if (got > 0 && int'(div_val) == prev) alt_bad++;
        prev = int'(div_val);
        if (got >= skip) begin
          sum += longint'(div_val);
          if (int'(div_val) < lo) lo = int'(div_val);
          if (int'(div_val) > hi) hi = int'(div_val);
        end
        got++;
      end
    end
    @(negedge clk);
    ref_stb = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PER * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    longint s;
    int lo, hi, v0, v1, ab, meff, feff;
    rst_n = 1'b0; ref_stb = 1'b0; order3 = 1'b0; dither_en = 1'b0;
    int_n = '0; frac_num = '0; frac_mod = '0;

    // R9: reset state at the ports
    do_reset(1'b1, 1'b0, 100, 1, 4);
    check("R9 vld after reset", longint'(div_vld), 0);
    check("R9 val after reset", longint'(div_val), 0);

    // Table walk: exact windowed sums (R1/R5/R6/R10) plus span (R2/R4)
    for (int v = 0; v < NVEC; v++) begin
      meff = VEC[v][3];
      feff = (VEC[v][2] >= meff) ? meff - 1 : VEC[v][2];
      do_reset(VEC[v][0] != 0, 1'b0, VEC[v][1], VEC[v][2], VEC[v][3]);
      collect(VEC[v][5], VEC[v][4], s, lo, hi, v0, v1, ab);
      check(tag_of(VEC[v][6]), s,
            longint'(VEC[v][5]) * VEC[v][1] + longint'(VEC[v][5]) * feff / meff);
      if (VEC[v][0] != 0) begin
        check("R4 span", longint'(lo >= VEC[v][1] - 3 && hi <= VEC[v][1] + 4), 1);
      end else begin
        check("R2 span", longint'(lo >= VEC[v][1] && hi <= VEC[v][1] + 1), 1);
      end
    end

    // R9: first value after reset in third order F=1 M=4 is N
    do_reset(1'b1, 1'b0, 100, 1, 4);
    collect(1, 0, s, lo, hi, v0, v1, ab);
    check("R9 first value", longint'(v0), 100);

    // R3: half fraction alternates, starting at N
    do_reset(1'b0, 1'b0, 50, 1, 2);
    collect(20, 0, s, lo, hi, v0, v1, ab);
    check("R3 first value", longint'(v0), 50);
    check("R3 second value", longint'(v1), 51);
    check("R3 repeats", longint'(ab), 0);

    // R8: idle strobe keeps vld low and value held
    v0 = int'(div_val);
    repeat (5) begin
      @(negedge clk);
      check("R8 idle vld", longint'(div_vld), 0);
      check("R8 idle hold", longint'(div_val), longint'(v0));
    end
    // R8: single strobe yields single pulse one clock later
    ref_stb = 1'b1;
    @(negedge clk);
    ref_stb = 1'b0;
    check("R8 pulse", longint'(div_vld), 1);
    @(negedge clk);
    check("R8 pulse ends", longint'(div_vld), 0);

    // R7: F=0 without dither stays at N
    do_reset(1'b0, 1'b0, 60, 0, 4);
    collect(100, 0, s, lo, hi, v0, v1, ab);
    check("R7 no dither", s, 6000);
    // R7: F=0 with dither rises above N, span still kept
    do_reset(1'b0, 1'b1, 60, 0, 4);
    collect(100, 0, s, lo, hi, v0, v1, ab);
    check("R7 dither moves", longint'(s > 6000), 1);
    check("R7 dither span", longint'(lo >= 60 && hi <= 61), 1);
    // R7 with R4: third order dithered span
    do_reset(1'b1, 1'b1, 60, 3, 5);
    collect(300, 0, s, lo, hi, v0, v1, ab);
    check("R7 third order span", longint'(lo >= 57 && hi <= 64), 1);

    // R6: modulus 0 treated as 1 with F clamped to 0
    do_reset(1'b0, 1'b0, 10, 3, 0);
    collect(8, 0, s, lo, hi, v0, v1, ab);
    check("R6 zero modulus", s, 80);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule